// File: doc/BRIEF.md
# Loss-of-Signal Alarm Qualifier

This block turns a raw "amplitude low" level from an analog line detector into a qualified loss-of-signal alarm. The raw level must stay asserted for a programmable time before the alarm is declared. The time is counted in ticks of a timing reference. A primary reference tick is used while that reference is reported present. Otherwise a secondary tick takes its place.

Two windows are available. The long window counts 4096 reference ticks, which is 2 ms at a 2.048 MHz reference and falls inside the 1 ms to 2.6 ms range. The short window counts 32 ticks, which are bit-symbol periods, and lands inside the 10 to 255 period range. Once declared, the alarm is captured in a status bit that stays set until software reads it. The read clears it. A new alarm also raises an interrupt level. The interrupt is raised only when neither the channel mask nor the global mask is set, and it is held until the status read.

The counter starts from zero at every new loss. Only the duration of the raw level matters, never the amplitude that came before it.

Top module: `los_alarm_timer`

## Requirements
- R1: After a synchronous active-low reset, `los_active`, `alarm_status` and `irq` are all 0.
- R2: With `win_sel`=0 and one reference tick per cycle, `los_active` rises on the clock edge that registers the 4096th consecutive tick with `amp_low` high, and not on an earlier edge.
- R3: With `win_sel`=1, `los_active` rises on the edge that registers the 32nd consecutive tick with `amp_low` high.
- R4: A cycle with `amp_low`=0 clears the tick count and `los_active` on the next edge, so a later loss needs the full window again.
- R5: With `pri_present`=1 only `pri_tick` advances the count. With `pri_present`=0 only `sec_tick` does. Cycles without the selected tick do not advance it.
- R6: `alarm_status` becomes 1 one cycle after `los_active` is 1. It stays 1 after `amp_low` falls, until a read.
- R7: `status_rd`=1 clears `alarm_status` on the next edge. If `los_active` is still 1, the status bit sets again on the edge after that, without a new interrupt.
- R8: `irq` sets one cycle after a 0-to-1 change of `los_active`, and only if `chan_mask`=0 and `glob_mask`=0 in that cycle.
- R9: Once set, `irq` holds at 1 until a `status_rd` cycle clears it on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| amp_low | input | 1 | Raw low-amplitude level from the line detector |
| win_sel | input | 1 | 0: long window (4096 ticks), 1: short window (32 ticks) |
| pri_present | input | 1 | Primary timing reference is running |
| pri_tick | input | 1 | One-cycle tick of the primary reference |
| sec_tick | input | 1 | One-cycle tick of the secondary reference |
| chan_mask | input | 1 | Channel interrupt mask, 1 blocks |
| glob_mask | input | 1 | Global interrupt mask, 1 blocks |
| status_rd | input | 1 | Read strobe of the status bit, clears it |
| los_active | output | 1 | Qualified alarm, live |
| alarm_status | output | 1 | Latched alarm, clear on read |
| irq | output | 1 | Interrupt level |

## Verification
A wrong tick count or a wrong terminal value moves the rising edge of `los_active` away from the exact edge that R2 and R3 call for. A cycle-accurate comparison catches that on the first alarm. A stale count left over after `amp_low` drops shows as an alarm that comes too early on the next loss. A wrong mask, edge or clear path shows at `irq` or `alarm_status` within one or two cycles of the event or the read. The comparison is made every cycle, including long stretches where nothing should change.

// File: rtl/los_pkg.sv
// Package: shared types for the loss-of-signal qualifier.
// Assumes nothing beyond the standard types.
package los_pkg;
    typedef enum logic {
        WIN_LONG  = 1'b0,
        WIN_SHORT = 1'b1
    } win_e;
endpackage

// File: rtl/los_ref_sel.sv
// Reference tick selector: passes the primary tick while the primary
// reference is present, else the secondary tick. Assumes both ticks are
// already synchronous one-cycle pulses in the clk domain.
module los_ref_sel (
    input  logic pri_present,
    input  logic pri_tick,
    input  logic sec_tick,
    output logic ref_tick
);
    // Pick the tick source by presence of the primary reference.
    always_comb begin
        ref_tick = pri_present ? pri_tick : sec_tick;
    end
endmodule

// File: rtl/los_qual_timer.sv
// Qualification timer: counts reference ticks while amp_low stays high and
// declares the alarm at the terminal count of the selected window.
// Assumes amp_low is synchronous to clk. Any low cycle restarts the count.
module los_qual_timer
    import los_pkg::*;
#(
    parameter int LONG_COUNT  = 4096,
    parameter int SHORT_COUNT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic amp_low,
    input  win_e win,
    input  logic ref_tick,
    output logic los_q
);
    localparam int MAX_COUNT = (LONG_COUNT > SHORT_COUNT) ? LONG_COUNT : SHORT_COUNT;
    localparam int CNT_W     = $clog2(MAX_COUNT + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected window and the next count value.
    always_comb begin
        limit   = (win == WIN_SHORT) ? CNT_W'(SHORT_COUNT) : CNT_W'(LONG_COUNT);
        cnt_inc = cnt + 1'b1;
    end

    // Tick counter and alarm flag, cleared whenever the raw level drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            los_q <= 1'b0;
        end else if (!amp_low) begin
            cnt   <= '0;
            los_q <= 1'b0;
        end else if (ref_tick && !los_q) begin
            cnt <= cnt_inc;
            if (cnt_inc >= limit) begin
                los_q <= 1'b1;
            end
        end
    end

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_low |=> !los_q); // R4
    AST_RISE_NEEDS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_q) |-> $past(amp_low) && $past(ref_tick)); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_COUNT)); // R3
endmodule

// File: rtl/los_status_irq.sv
// Status and interrupt: latches the qualified alarm into a clear-on-read
// bit and raises a held interrupt on each new alarm when both masks are
// clear. Assumes status_rd is a one-cycle strobe.
module los_status_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic los_q,
    input  logic chan_mask,
    input  logic glob_mask,
    input  logic status_rd,
    output logic alarm_status,
    output logic irq
);
    logic los_d;
    logic rise_ok;

    // New alarm that is allowed through both masks.
    always_comb begin
        rise_ok = los_q && !los_d && !chan_mask && !glob_mask;
    end

    // Delayed alarm for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) los_d <= 1'b0;
        else        los_d <= los_q;
    end

    // Clear-on-read status bit that sets again while the alarm persists.
    always_ff @(posedge clk) begin
        if (!rst_n)          alarm_status <= 1'b0;
        else if (status_rd)  alarm_status <= 1'b0;
        else if (los_q)      alarm_status <= 1'b1;
    end

    // Interrupt level: set on an unmasked new alarm, held until a read.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq <= 1'b0;
        else if (rise_ok)    irq <= 1'b1;
        else if (status_rd)  irq <= 1'b0;
    end

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_status && !status_rd |=> alarm_status); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> !alarm_status); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(!chan_mask && !glob_mask && los_q)); // R8
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !status_rd |=> irq); // R9
endmodule

// File: rtl/los_alarm_timer.sv
// Top: loss-of-signal alarm qualifier. Selects the timing tick, qualifies
// the raw low-amplitude level over the chosen window, and exposes a latched
// status bit and a masked interrupt. Assumes all inputs are in the clk domain.
module los_alarm_timer
    import los_pkg::*;
#(
    parameter int LONG_COUNT  = 4096,
    parameter int SHORT_COUNT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic amp_low,
    input  logic win_sel,
    input  logic pri_present,
    input  logic pri_tick,
    input  logic sec_tick,
    input  logic chan_mask,
    input  logic glob_mask,
    input  logic status_rd,
    output logic los_active,
    output logic alarm_status,
    output logic irq
);
    logic ref_tick;
    win_e win;

    // Map the mode pin onto the window type.
    always_comb begin
        win = win_e'(win_sel);
    end

    los_ref_sel u_ref_sel (
        .pri_present (pri_present),
        .pri_tick    (pri_tick),
        .sec_tick    (sec_tick),
        .ref_tick    (ref_tick)
    );

    los_qual_timer #(
        .LONG_COUNT  (LONG_COUNT),
        .SHORT_COUNT (SHORT_COUNT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .amp_low  (amp_low),
        .win      (win),
        .ref_tick (ref_tick),
        .los_q    (los_active)
    );

    los_status_irq u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .los_q        (los_active),
        .chan_mask    (chan_mask),
        .glob_mask    (glob_mask),
        .status_rd    (status_rd),
        .alarm_status (alarm_status),
        .irq          (irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !los_active && !alarm_status && !irq); // R1
endmodule

// File: tb/los_alarm_timer_bench.sv
module los_alarm_timer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic amp_low = 1'b0, win_sel = 1'b0, pri_present = 1'b1;
    logic pri_tick = 1'b0, sec_tick = 1'b0;
    logic chan_mask = 1'b0, glob_mask = 1'b0, status_rd = 1'b0;
    logic los_active, alarm_status, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic  los;
        logic  stat;
        logic  irq;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    // Reference model state, built from the requirements.
    int   m_cnt  = 0;
    logic m_los  = 1'b0;
    logic m_losd = 1'b0;
    logic m_stat = 1'b0;
    logic m_irq  = 1'b0;

    always #5 clk = ~clk;

    los_alarm_timer u_los_alarm_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .amp_low      (amp_low),
        .win_sel      (win_sel),
        .pri_present  (pri_present),
        .pri_tick     (pri_tick),
        .sec_tick     (sec_tick),
        .chan_mask    (chan_mask),
        .glob_mask    (glob_mask),
        .status_rd    (status_rd),
        .los_active   (los_active),
        .alarm_status (alarm_status),
        .irq          (irq)
    );

    // Driver: for each cycle, predict the state after the next edge and queue it.
    task automatic cyc(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic tick;
            int   lim;
            logic rise;
            logic n_los, n_stat, n_irq;
            int   n_cnt;
            exp_t e;
            tick = pri_present ? pri_tick : sec_tick;
            lim  = win_sel ? 32 : 4096;
            rise = m_los && !m_losd;
            n_cnt = m_cnt;
            n_los = m_los;
            if (!amp_low) begin
                n_cnt = 0;
                n_los = 1'b0;
            end else if (tick && !m_los) begin
                n_cnt = m_cnt + 1;
                if (n_cnt >= lim) n_los = 1'b1;
            end
            n_stat = status_rd ? 1'b0 : (m_los ? 1'b1 : m_stat);
            n_irq  = (rise && !chan_mask && !glob_mask) ? 1'b1 : (status_rd ? 1'b0 : m_irq);
            if (!rst_n) begin
                n_cnt = 0; n_los = 0; n_stat = 0; n_irq = 0;
            end
            m_losd = rst_n ? m_los : 1'b0;
            m_cnt  = n_cnt;
            m_los  = n_los;
            m_stat = n_stat;
            m_irq  = n_irq;
            e.los = n_los; e.stat = n_stat; e.irq = n_irq; e.tag = tag;
            exp_q.push_back(e);
            @(negedge clk);
        end
    endtask

    task automatic read_pulse(input string tag);
        status_rd = 1'b1;
        cyc(1, tag);
        status_rd = 1'b0;
    endtask

    // Monitor: after each edge, pop the prediction and compare the outputs.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if ({los_active, alarm_status, irq} !== {e.los, e.stat, e.irq}) begin
                n_fail++;
                $display("FAIL %s at %0t: actual los/stat/irq=%b%b%b expected=%b%b%b",
                         e.tag, $time, los_active, alarm_status, irq, e.los, e.stat, e.irq);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(3, "R1 reset");
        rst_n = 1'b1;
        cyc(2, "R1 idle");

        // Short window on the primary tick, masks clear.
        win_sel = 1'b1; pri_present = 1'b1; pri_tick = 1'b1; amp_low = 1'b1;
        cyc(40, "R3 short window, R8 irq");
        amp_low = 1'b0;
        cyc(6, "R6 R9 hold after loss ends");
        read_pulse("R7 read");
        cyc(3, "R7 R9 cleared");

        // Interrupted loss restarts the count.
        amp_low = 1'b1;
        cyc(20, "R4 partial");
        amp_low = 1'b0;
        cyc(1, "R4 drop");
        amp_low = 1'b1;
        cyc(31, "R4 no early alarm");
        cyc(4, "R4 full window");

        // Read while alarm persists.
        read_pulse("R7 read while active");
        cyc(5, "R7 re-set without irq");
        amp_low = 1'b0;
        cyc(2, "R6 after drop");
        read_pulse("R7 read");

        // Channel mask then global mask.
        chan_mask = 1'b1; amp_low = 1'b1;
        cyc(36, "R8 channel mask");
        amp_low = 1'b0; cyc(1, "R8"); read_pulse("R8");
        chan_mask = 1'b0; glob_mask = 1'b1; amp_low = 1'b1;
        cyc(36, "R8 global mask");
        amp_low = 1'b0; cyc(1, "R8"); read_pulse("R8");
        glob_mask = 1'b0;

        // Tick source selection.
        pri_tick = 1'b0; sec_tick = 1'b1; amp_low = 1'b1;
        cyc(40, "R5 secondary ignored");
        amp_low = 1'b0; cyc(1, "R5");
        pri_present = 1'b0; amp_low = 1'b1;
        cyc(40, "R5 fallback to secondary");
        amp_low = 1'b0; cyc(1, "R5"); read_pulse("R5");
        pri_present = 1'b1; pri_tick = 1'b0; sec_tick = 1'b0;
        amp_low = 1'b1;
        for (int k = 0; k < 40; k++) begin
            pri_tick = k[0];
            cyc(1, "R5 sparse ticks");
        end
        amp_low = 1'b0; cyc(1, "R5"); read_pulse("R5");

        // Long window.
        win_sel = 1'b0; pri_tick = 1'b1; amp_low = 1'b1;
        cyc(4100, "R2 long window");
        amp_low = 1'b0;
        cyc(3, "R9 hold");
        read_pulse("R9 read");
        cyc(3, "R9 cleared");

        repeat (2) @(posedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule